// File: doc/BRIEF.md
# Four-Channel PWM Generator with Staged Configuration

This block drives four independent pulse-width outputs from a shared 1 MHz tick. Each channel has three registers on a small synchronous bus: a period length, an active length and a control word. The control word holds a 2-bit divider select and an inversion flag. Values written by software are held in staging registers. They reach the running waveform only as one set, at a moment the channel picks. That way a pulse train never mixes old and new settings.

Writing the period register arms the transfer. A running channel takes the staged set when its current period ends. A channel that is not running takes it on its next divided tick. A period value of zero lets the current period run out and then parks the output low. Reads return the staged values, so software sees what it last wrote.

Top module: `pwm_quad_shadow`

## Requirements
- R1: A synchronous active-high `rst` clears all registers and counters, drives every `pwmOut` bit low, and makes every register read return 0.
- R2: Register addresses (byte, 12 bits) are 0x400+4*ch for period, 0x420+4*ch for active length and 0x440+4*ch for control, ch = 0..3. A read returns the last value written. For control, only bits [1:0] (divider select) and bit 5 (invert) are kept, and the other bits read as 0.
- R3: Writing the active length or the control word without a following period write never changes the waveform.
- R4: A period write to a running channel takes effect, together with the staged active length and control, at the end of the period in progress. The counter then restarts from zero.
- R5: A period write to an idle channel takes effect on that channel's next divided tick.
- R6: Within a period of P count units, the output is active while the count is below the active length D and inactive for the remaining units.
- R7: An active length D >= P holds the output at its active level for the whole period.
- R8: With control bit 5 set, the active level is low and the inactive level is high.
- R9: With divider select n, one count unit lasts 2^n input ticks, so a period lasts P*2^n ticks.
- R10: A period write of 0 lets the running period finish and then holds the output low (even when inverted) until a new nonzero period is committed.
- R11: Channels are independent: a write to one channel changes no other channel's output or readback.
- R12: Writes to addresses outside the map (other upper nibble, 0x410-0x41C, 0x460 and above, unaligned) are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 1 MHz, the base time unit |
| busAddr | input | 12 | Byte address for read and write |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 4 | One waveform output per channel |

## Verification
A register write lands on the clock edge where `busWe` is high, and `busRdata` shows it from that edge onward with no extra latency. A commit happens on the edge of a divided tick, and `pwmOut` shows the new setting in the same cycle, because the output decodes registered state without an added stage. The bench drives inputs shortly after each rising edge. It moves a behavioural model on the same edge and compares `pwmOut` and `busRdata` against it at the falling edge of every cycle, so each result is judged in the cycle it is due. Readback, disable and full-duty cases add directed checks at known points.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int DW      = 32;
  localparam int DIV_W   = 2;
  localparam int INV_BIT = 5;
  localparam int PRE_W   = (1 << DIV_W) - 1;

  // control -> datapath: commit strobe plus the staged setting it carries
  typedef struct packed {
    logic            commit;
    logic [DW-1:0]   period;
    logic [DW-1:0]   duty;
    logic [DIV_W-1:0] div;
    logic            invert;
  } chStrobe_t;

  // datapath -> control: channel can accept a staged setting now
  typedef struct packed {
    logic ready;
  } chStatus_t;
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  chStatus_t         status [NCH],
  output chStrobe_t         strobe [NCH]
);
  localparam int GRP_PERIOD = 0;
  localparam int GRP_DUTY   = 1;
  localparam int GRP_CTRL   = 2;

  logic          baseHit, aligned, regHit;
  logic [2:0]    grp;
  logic [2:0]    chIdx;

  assign baseHit = busAddr[ADDR_W-1:8] == (ADDR_W-8)'(4);
  assign grp     = busAddr[7:5];
  assign chIdx   = busAddr[4:2];
  assign aligned = busAddr[1:0] == 2'b00;
  assign regHit  = baseHit && aligned && (int'(chIdx) < NCH) && (int'(grp) <= GRP_CTRL);

  logic [DW-1:0]    stPeriod [NCH];
  logic [DW-1:0]    stDuty   [NCH];
  logic [DIV_W-1:0] stDiv    [NCH];
  logic             stInv    [NCH];
  logic [NCH-1:0]   pending;
  logic [NCH-1:0]   commitNow;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic selCh, perWr, dutyWr, ctlWr;
    assign selCh  = busWe && regHit && (int'(chIdx) == ch);
    assign perWr  = selCh && (int'(grp) == GRP_PERIOD);
    assign dutyWr = selCh && (int'(grp) == GRP_DUTY);
    assign ctlWr  = selCh && (int'(grp) == GRP_CTRL);
    assign commitNow[ch] = pending[ch] && status[ch].ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        stPeriod[ch] <= '0;
        stDuty[ch]   <= '0;
        stDiv[ch]    <= '0;
        stInv[ch]    <= 1'b0;
        pending[ch]  <= 1'b0;
      end else begin
        if (perWr)  stPeriod[ch] <= busWdata;
        if (dutyWr) stDuty[ch]   <= busWdata;
        if (ctlWr) begin
          stDiv[ch] <= busWdata[DIV_W-1:0];
          stInv[ch] <= busWdata[INV_BIT];
        end
        pending[ch] <= perWr || (pending[ch] && !commitNow[ch]);
      end
    end

    assign strobe[ch] = '{commit: commitNow[ch], period: stPeriod[ch],
                          duty: stDuty[ch], div: stDiv[ch], invert: stInv[ch]};
  end

  always_comb begin
    busRdata = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (regHit && int'(chIdx) == ch) begin
        case (int'(grp))
          GRP_PERIOD: busRdata = stPeriod[ch];
          GRP_DUTY:   busRdata = stDuty[ch];
          default: begin
            busRdata[DIV_W-1:0] = stDiv[ch];
            busRdata[INV_BIT]   = stInv[ch];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_quad_dp.sv
module pwm_quad_dp
  import pwm_quad_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  chStrobe_t      strobe [NCH],
  output chStatus_t      status [NCH],
  output logic [NCH-1:0] pwmOut
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0]    actPeriod, actDuty, cnt;
    logic [DIV_W-1:0] actDiv;
    logic             actInv, running;
    logic [PRE_W-1:0] preCnt;
    logic [PRE_W:0]   preLim;
    logic             divTick, lastUnit;

    assign preLim   = ({{PRE_W{1'b0}}, 1'b1} << actDiv) - 1'b1;
    assign divTick  = tick && (preCnt == preLim[PRE_W-1:0]);
    assign lastUnit = cnt == actPeriod - 1'b1;
    assign status[ch].ready = divTick && (!running || lastUnit);

    always_ff @(posedge clk) begin
      if (rst) begin
        actPeriod <= '0;
        actDuty   <= '0;
        actDiv    <= '0;
        actInv    <= 1'b0;
        running   <= 1'b0;
        cnt       <= '0;
        preCnt    <= '0;
      end else if (strobe[ch].commit) begin
        actPeriod <= strobe[ch].period;
        actDuty   <= strobe[ch].duty;
        actDiv    <= strobe[ch].div;
        actInv    <= strobe[ch].invert;
        running   <= strobe[ch].period != '0;
        cnt       <= '0;
        preCnt    <= '0;
      end else begin
        if (tick) preCnt <= divTick ? '0 : preCnt + 1'b1;
        if (divTick && running) cnt <= lastUnit ? '0 : cnt + 1'b1;
      end
    end

    assign pwmOut[ch] = running && ((cnt < actDuty) ^ actInv);
  end
endmodule

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic [NCH-1:0]    pwmOut
);
  chStrobe_t strobe [NCH];
  chStatus_t status [NCH];

  pwm_quad_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .status(status), .strobe(strobe)
  );

  pwm_quad_dp #(.NCH(NCH)) u_dp (
    .clk(clk), .rst(rst), .tick(tick), .strobe(strobe),
    .status(status), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_quad_shadow_chk.sv
module pwm_quad_shadow_chk
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DW-1:0]     busWdata,
  input logic [DW-1:0]     busRdata,
  input logic [NCH-1:0]    pwmOut,
  input chStrobe_t         strobe [NCH]
);
  // R1: first cycle out of reset shows all outputs low
  a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pwmOut == '0);

  // R2: a period write to channel 0 reads back from the next cycle on
  a_r2_period_readback: assert property (@(posedge clk) disable iff (rst)
    (busWe && busAddr == ADDR_W'(12'h400)) |=>
      (busAddr != ADDR_W'(12'h400) || busRdata == $past(busWdata)));

  // R12: addresses outside the upper nibble read as zero
  a_r12_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (busAddr[ADDR_W-1:8] != (ADDR_W-8)'(4)) |-> busRdata == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // R5: any commit coincides with an input tick
    a_r5_commit_on_tick: assert property (@(posedge clk) disable iff (rst)
      strobe[ch].commit |-> tick);

    // R10: committing a zero period parks the output low
    a_r10_zero_period_low: assert property (@(posedge clk) disable iff (rst)
      (strobe[ch].commit && strobe[ch].period == '0) |=> !pwmOut[ch]);
  end
endmodule

bind pwm_quad_shadow pwm_quad_shadow_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut), .strobe(strobe)
);

// File: tb/sim_pwm_quad_shadow.sv
`timescale 1ns/1ps
module sim_pwm_quad_shadow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFail   = 0;
  string curReq = "R1";
  bit tickOn = 1'b1;
  int tickCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_quad_shadow u0 (
    .clk(clk), .rst(rst), .tick(tick), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  // tick generator: one pulse every 4 clocks
  always @(posedge clk) begin
    #2;
    tickCnt = (tickCnt + 1) % 4;
    tick = tickOn && (tickCnt == 0);
  end

  // behavioural reference model
  int unsigned mPer[4], mDuty[4], mDiv[4], mInv[4], mRun[4], mCnt[4], mPre[4];
  int unsigned sPer[4], sDuty[4], sCtl[4], pend[4];

  function automatic int unsigned modelRead(input logic [11:0] a);
    int g, c;
    if (a < 12'h400 || a >= 12'h460 || a[1:0] != 2'b00 || a[4]) return 0;
    g = (int'(a) - 'h400) / 32;
    c = (int'(a) / 4) % 4;
    if (g == 0) return sPer[c];
    if (g == 1) return sDuty[c];
    return sCtl[c];
  endfunction

  function automatic bit modelOut(input int c);
    bit act;
    if (mRun[c] == 0) return 1'b0;
    act = mCnt[c] < mDuty[c];
    return (mInv[c] != 0) ? !act : act;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        mPer[c] = 0; mDuty[c] = 0; mDiv[c] = 0; mInv[c] = 0; mRun[c] = 0;
        mCnt[c] = 0; mPre[c] = 0; sPer[c] = 0; sDuty[c] = 0; sCtl[c] = 0; pend[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        int unsigned lim;
        bit dt, rdy;
        lim = (1 << mDiv[c]) - 1;
        dt  = tick && (mPre[c] == lim);
        rdy = dt && (mRun[c] == 0 || mCnt[c] == mPer[c] - 1);
        if (pend[c] != 0 && rdy) begin
          mPer[c] = sPer[c]; mDuty[c] = sDuty[c];
          mDiv[c] = sCtl[c] & 3; mInv[c] = (sCtl[c] >> 5) & 1;
          mRun[c] = (sPer[c] != 0); mCnt[c] = 0; mPre[c] = 0; pend[c] = 0;
        end else begin
          if (tick) mPre[c] = dt ? 0 : mPre[c] + 1;
          if (dt && mRun[c] != 0) mCnt[c] = (mCnt[c] == mPer[c] - 1) ? 0 : mCnt[c] + 1;
        end
      end
      if (busWe && busAddr >= 12'h400 && busAddr < 12'h460 &&
          busAddr[1:0] == 2'b00 && !busAddr[4]) begin
        int g, c;
        g = (int'(busAddr) - 'h400) / 32;
        c = (int'(busAddr) / 4) % 4;
        if (g == 0) begin sPer[c] = busWdata; pend[c] = 1; end
        else if (g == 1) sDuty[c] = busWdata;
        else sCtl[c] = busWdata & 32'h23;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [3:0] expOut;
      logic [31:0] expRd;
      for (int c = 0; c < 4; c++) expOut[c] = modelOut(c);
      expRd = modelRead(busAddr);
      nChecks++;
      if (pwmOut !== expOut || busRdata !== expRd) begin
        nFail++;
        $display("FAIL %s t=%0t pwmOut=%b exp=%b rdata=%h exp=%h",
                 curReq, $time, pwmOut, expOut, busRdata, expRd);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(posedge clk); #2;
    busWe = 1'b0;
  endtask

  task automatic rdCheck(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #2;
    busAddr = a;
    @(negedge clk);
    nChecks++;
    if (busRdata !== exp) begin
      nFail++;
      $display("FAIL %s read %h actual=%h expected=%h", req, a, busRdata, exp);
    end
  endtask

  task automatic outCheck(input int c, input logic exp, input string req);
    @(negedge clk);
    nChecks++;
    if (pwmOut[c] !== exp) begin
      nFail++;
      $display("FAIL %s ch%0d actual=%b expected=%b", req, c, pwmOut[c], exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;

    // R1: reset state
    curReq = "R1";
    outCheck(0, 1'b0, "R1");
    rdCheck(12'h400, 32'h0, "R1");
    rdCheck(12'h44C, 32'h0, "R1");

    // R2 readback and masking; R9 divider; R8 polarity; R7 full duty
    curReq = "R2";
    wr(12'h420, 32'd2);  wr(12'h440, 32'h0);  wr(12'h400, 32'd5);
    wr(12'h424, 32'd9);  wr(12'h444, 32'h1);  wr(12'h404, 32'd4);
    wr(12'h428, 32'd1);  wr(12'h448, 32'h20); wr(12'h408, 32'd6);
    wr(12'h42C, 32'd1);  wr(12'h44C, 32'hFFFF_FFFF); wr(12'h40C, 32'd3);
    rdCheck(12'h400, 32'd5, "R2");
    rdCheck(12'h424, 32'd9, "R2");
    rdCheck(12'h44C, 32'h23, "R2");
    curReq = "R6";
    idle(200);
    curReq = "R7";
    for (int i = 0; i < 40; i++) outCheck(1, 1'b1, "R7");
    curReq = "R9";
    idle(200);

    // R3: staged duty/control without period write
    curReq = "R3";
    wr(12'h420, 32'd4);
    wr(12'h440, 32'h21);
    rdCheck(12'h420, 32'd4, "R3");
    idle(300);

    // R4: period write to running channel
    curReq = "R4";
    wr(12'h400, 32'd7);
    idle(300);

    // R10: zero period, then R5 restart from idle
    curReq = "R10";
    wr(12'h408, 32'd0);
    idle(200);
    for (int i = 0; i < 20; i++) outCheck(2, 1'b0, "R10");
    curReq = "R5";
    wr(12'h428, 32'd3);
    wr(12'h448, 32'h0);
    wr(12'h408, 32'd4);
    idle(150);

    // R8: inverted polarity with partial duty
    curReq = "R8";
    wr(12'h44C, 32'h20);
    wr(12'h40C, 32'd5);
    idle(200);

    // R12: out-of-map accesses
    curReq = "R12";
    wr(12'h410, 32'hDEAD_BEEF);
    wr(12'h460, 32'h1234_5678);
    wr(12'h401, 32'h0000_0009);
    wr(12'h800, 32'h0000_0001);
    rdCheck(12'h410, 32'h0, "R12");
    rdCheck(12'h460, 32'h0, "R12");
    rdCheck(12'h400, 32'd7, "R12");

    // R11: independence, one channel rewritten, others keep running
    curReq = "R11";
    wr(12'h404, 32'd0);
    rdCheck(12'h408, 32'd4, "R11");
    idle(200);

    // mixed writes across all channels
    curReq = "R6";
    for (int i = 0; i < 40; i++) begin
      logic [11:0] a;
      int c, g;
      c = $urandom_range(0, 3);
      g = $urandom_range(0, 2);
      a = 12'h400 + 12'(32 * g) + 12'(4 * c);
      wr(a, (g == 2) ? $urandom() : $urandom_range(0, 7));
      idle($urandom_range(5, 120));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule